// File: doc/BRIEF.md
# Four-Operand Redundant Digit Encoder

This block is the first reduction level of a multiplier's partial-product tree. It takes four binary operands of equal width and, with no carry rippling across the word, turns their sum into a row of radix-2 digits, each worth 0, 1, 2 or 3. Every bit position is one identical column slice. Three of the four operand bits go into an ordinary full adder. That adder makes a digit bit `d` and a transfer bit that moves one position up. The fourth operand bit and the transfer bit that arrives from the position below are packed into a bit pair `(e, f)`. The digit value is `d + e + f`.

The three-bit code is constrained: the pair `(e, f) = (1, 0)` is never produced. Because of this, a cheap converter can fold each digit into a weighted two-bit form `(t, w)` with value `2t + w`. This needs fewer wires for the next tree level, which can use either form. The transfer bit out of the top position becomes one extra digit above the operand width, so the output row has N+1 digits. The block is purely combinational and holds no state.

Top module: `rd_four_op_encoder`

## Requirements
- R1: With all four operands zero, every output bit (`dig_d`, `dig_e`, `dig_f`, `dig_t`, `dig_w`) is zero.
- R2: At no digit position j (0..N) is the pair (`dig_e[j]`, `dig_f[j]`) equal to (1, 0).
- R3: The weighted digit sum, Σ over j=0..N of (`dig_d[j]` + `dig_e[j]` + `dig_f[j]`)·2^j, equals `opnd_a + opnd_b + opnd_c + opnd_x` as an unsigned (N+2)-bit number.
- R4: For j < N, `dig_d[j]` equals `opnd_a[j]` XOR `opnd_b[j]` XOR `opnd_c[j]`. The transfer out of position j is the majority of those three bits.
- R5: For j < N, `dig_e[j]` = `opnd_x[j]` AND tin_j and `dig_f[j]` = `opnd_x[j]` OR tin_j. Here tin_j is the transfer out of position j-1, and tin_0 = 0. So `dig_e[0]` is always 0 and `dig_f[0]` = `opnd_x[0]`.
- R6: The top digit N has `dig_d[N]` = 0, `dig_e[N]` = 0 and `dig_f[N]` = majority(`opnd_a[N-1]`, `opnd_b[N-1]`, `opnd_c[N-1]`).
- R7: At every position j (0..N), 2·`dig_t[j]` + `dig_w[j]` equals `dig_d[j]` + `dig_e[j]` + `dig_f[j]`.
- R8: With all four operands all-ones, digit 0 has value 2, digits 1 to N-1 have value 3, and digit N has value 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | N | First operand, fed to the full-adder part |
| opnd_b | input | N | Second operand, fed to the full-adder part |
| opnd_c | input | N | Third operand, fed to the full-adder part |
| opnd_x | input | N | Fourth operand, fed to the pair encoder |
| dig_d | output | N+1 | Full-adder digit bit of each position |
| dig_e | output | N+1 | Lower pair bit `e` of each position |
| dig_f | output | N+1 | Lower pair bit `f` of each position |
| dig_t | output | N+1 | Weight-two bit of the compact code |
| dig_w | output | N+1 | Weight-one bit of the compact code |

## Verification
The in-line immediate assertions assume that every operand bit is a known 0 or 1. They skip evaluation while any input holds X or Z, so the undriven state at time zero raises nothing. The stimulus drives all four operands together on a clock edge from a fully defined table or from directed values, and never leaves a bit undefined after the first vector. The checks assume no input ordering or handshake: every output is a pure function of the operands present in the same cycle.

// File: rtl/rd_enc_pkg.sv
package rd_enc_pkg;

  typedef struct packed {
    logic d;
    logic e;
    logic f;
  } dig3_t;

  typedef struct packed {
    logic t;
    logic w;
  } dig2_t;

  function automatic logic [1:0] dig3_value(input dig3_t g);
    return {1'b0, g.d} + {1'b0, g.e} + {1'b0, g.f};
  endfunction

  function automatic logic [1:0] dig2_value(input dig2_t c);
    return {c.t, c.w};
  endfunction

endpackage

// File: rtl/rd_upper_fa.sv
module rd_upper_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic sum_o,
  output logic carry_o
);
  logic half_x;

  always_comb begin
    half_x  = a_i ^ b_i;
    sum_o   = half_x ^ c_i;
    carry_o = (a_i & b_i) | (c_i & half_x);
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, c_i})) begin
      AST_FA_BALANCE: assert ({1'b0, a_i} + {1'b0, b_i} + {1'b0, c_i} == {carry_o, sum_o}) else $error("full adder out of balance"); // R4
    end
  end
endmodule

// File: rtl/rd_lower_enc.sv
module rd_lower_enc (
  input  logic x_i,
  input  logic tin_i,
  output logic e_o,
  output logic f_o
);
  always_comb begin
    e_o = x_i & tin_i;
    f_o = x_i | tin_i;
  end

  always_comb begin
    if (!$isunknown({x_i, tin_i})) begin
      AST_LEGAL_PAIR: assert (!(e_o && !f_o)) else $error("illegal pair (1,0)"); // R2
      AST_PAIR_VALUE: assert ({1'b0, e_o} + {1'b0, f_o} == {1'b0, x_i} + {1'b0, tin_i}) else $error("pair value wrong"); // R5
    end
  end
endmodule

// File: rtl/rd_code_conv.sv
module rd_code_conv
  import rd_enc_pkg::*;
(
  input  dig3_t din_i,
  output dig2_t dout_o
);
  always_comb begin
    dout_o.w = din_i.d ^ din_i.e ^ din_i.f;
    dout_o.t = din_i.e | (din_i.d & din_i.f);
  end

  always_comb begin
    if (!$isunknown(din_i) && !(din_i.e && !din_i.f)) begin
      AST_TWO_BIT_MATCH: assert (dig2_value(dout_o) == dig3_value(din_i)) else $error("compact code mismatch"); // R7
    end
  end
endmodule

// File: rtl/rd_column_slice.sv
module rd_column_slice
  import rd_enc_pkg::*;
(
  input  logic  a_i,
  input  logic  b_i,
  input  logic  c_i,
  input  logic  x_i,
  input  logic  tin_i,
  output dig3_t dig_o,
  output dig2_t code_o,
  output logic  tout_o
);
  logic fa_sum;
  logic pair_e;
  logic pair_f;

  rd_upper_fa u_fa (
    .a_i     (a_i),
    .b_i     (b_i),
    .c_i     (c_i),
    .sum_o   (fa_sum),
    .carry_o (tout_o)
  );

  rd_lower_enc u_enc (
    .x_i   (x_i),
    .tin_i (tin_i),
    .e_o   (pair_e),
    .f_o   (pair_f)
  );

  always_comb begin
    dig_o.d = fa_sum;
    dig_o.e = pair_e;
    dig_o.f = pair_f;
  end

  rd_code_conv u_conv (
    .din_i  (dig_o),
    .dout_o (code_o)
  );
endmodule

// File: rtl/rd_four_op_encoder.sv
module rd_four_op_encoder
  import rd_enc_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] opnd_a,
  input  logic [N-1:0] opnd_b,
  input  logic [N-1:0] opnd_c,
  input  logic [N-1:0] opnd_x,
  output logic [N:0]   dig_d,
  output logic [N:0]   dig_e,
  output logic [N:0]   dig_f,
  output logic [N:0]   dig_t,
  output logic [N:0]   dig_w
);
  localparam int ND = N + 1;
  localparam int SW = N + 2;

  logic  [N:0]  xfer;
  dig3_t        digs  [ND];
  dig2_t        codes [ND];

  assign xfer[0] = 1'b0;

  for (genvar j = 0; j < N; j++) begin : g_col
    rd_column_slice u_slice (
      .a_i    (opnd_a[j]),
      .b_i    (opnd_b[j]),
      .c_i    (opnd_c[j]),
      .x_i    (opnd_x[j]),
      .tin_i  (xfer[j]),
      .dig_o  (digs[j]),
      .code_o (codes[j]),
      .tout_o (xfer[j+1])
    );
  end

  always_comb begin
    digs[N].d = 1'b0;
    digs[N].e = 1'b0;
    digs[N].f = xfer[N];
  end

  rd_code_conv u_top_conv (
    .din_i  (digs[N]),
    .dout_o (codes[N])
  );

  for (genvar j = 0; j < ND; j++) begin : g_out
    assign dig_d[j] = digs[j].d;
    assign dig_e[j] = digs[j].e;
    assign dig_f[j] = digs[j].f;
    assign dig_t[j] = codes[j].t;
    assign dig_w[j] = codes[j].w;
  end

  logic [SW-1:0] chk_digits;
  logic [SW-1:0] chk_opnds;

  always_comb begin
    chk_digits = '0;
    for (int j = 0; j < ND; j++) begin
      chk_digits = chk_digits + ({{(SW-2){1'b0}}, dig3_value(digs[j])} << j);
    end
    chk_opnds = {2'b00, opnd_a} + {2'b00, opnd_b} + {2'b00, opnd_c} + {2'b00, opnd_x};
  end

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, opnd_c, opnd_x})) begin
      AST_WEIGHTED_SUM: assert (chk_digits == chk_opnds) else $error("digit row does not sum to operands"); // R3
      AST_BOTTOM_PAIR: assert (dig_e[0] == 1'b0 && dig_f[0] == opnd_x[0]) else $error("position 0 pair wrong"); // R5
      AST_TOP_DIGIT: assert (dig_d[N] == 1'b0 && dig_e[N] == 1'b0) else $error("top digit carries extra bits"); // R6
      AST_ZERO_IN: assert ((|{opnd_a, opnd_b, opnd_c, opnd_x}) || !(|{dig_d, dig_e, dig_f, dig_t, dig_w})) else $error("zero input gives nonzero row"); // R1
    end
  end
endmodule

// File: tb/rd_four_op_encoder_test.sv
module rd_four_op_encoder_test;
  localparam int N = 16;

  typedef struct packed {
    logic [N-1:0] a;
    logic [N-1:0] b;
    logic [N-1:0] c;
    logic [N-1:0] x;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000},
    '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    '{16'hAAAA, 16'h5555, 16'hAAAA, 16'h5555},
    '{16'h1234, 16'h8765, 16'hFFFF, 16'h0001},
    '{16'h8000, 16'h8000, 16'h8000, 16'h8000},
    '{16'h0001, 16'h0000, 16'h0000, 16'h0001},
    '{16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hF00D},
    '{16'hFFFF, 16'h0001, 16'h0000, 16'hFFFF},
    '{16'h7FFF, 16'h7FFF, 16'h0000, 16'h8001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] opnd_a = '0, opnd_b = '0, opnd_c = '0, opnd_x = '0;
  logic [N:0] dig_d, dig_e, dig_f, dig_t, dig_w;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rd_four_op_encoder #(.N(N)) uut (
    .opnd_a (opnd_a), .opnd_b (opnd_b), .opnd_c (opnd_c), .opnd_x (opnd_x),
    .dig_d (dig_d), .dig_e (dig_e), .dig_f (dig_f), .dig_t (dig_t), .dig_w (dig_w)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(posedge clk);
    opnd_a = v.a; opnd_b = v.b; opnd_c = v.c; opnd_x = v.x;
    @(negedge clk);
  endtask

  function automatic int dval(input int j);
    return int'(dig_d[j]) + int'(dig_e[j]) + int'(dig_f[j]);
  endfunction

  task automatic check_row(input vec_t v);
    logic [N+1:0] exp_sum;
    logic [N+1:0] got_sum;
    logic tin;
    logic maj;
    exp_sum = {2'b00, v.a} + {2'b00, v.b} + {2'b00, v.c} + {2'b00, v.x};
    got_sum = '0;
    for (int j = 0; j <= N; j++) got_sum = got_sum + ((N+2)'(dval(j)) << j);
    check(got_sum == exp_sum, "R3", "weighted digit sum", 64'(got_sum), 64'(exp_sum));
    tin = 1'b0;
    for (int j = 0; j < N; j++) begin
      maj = (v.a[j] & v.b[j]) | (v.a[j] & v.c[j]) | (v.b[j] & v.c[j]);
      check(dig_d[j] == (v.a[j] ^ v.b[j] ^ v.c[j]), "R4", $sformatf("d bit %0d", j),
            64'(dig_d[j]), 64'(v.a[j] ^ v.b[j] ^ v.c[j]));
      check({dig_e[j], dig_f[j]} == {v.x[j] & tin, v.x[j] | tin}, "R5", $sformatf("e,f bits %0d", j),
            64'({dig_e[j], dig_f[j]}), 64'({v.x[j] & tin, v.x[j] | tin}));
      tin = maj;
    end
    check({dig_d[N], dig_e[N], dig_f[N]} == {2'b00, tin}, "R6", "top digit d,e,f",
          64'({dig_d[N], dig_e[N], dig_f[N]}), 64'({2'b00, tin}));
    for (int j = 0; j <= N; j++) begin
      check(!(dig_e[j] && !dig_f[j]), "R2", $sformatf("pair legal at %0d", j),
            64'({dig_e[j], dig_f[j]}), 64'h3);
      check(2 * int'(dig_t[j]) + int'(dig_w[j]) == dval(j), "R7", $sformatf("compact code at %0d", j),
            64'(2 * int'(dig_t[j]) + int'(dig_w[j])), 64'(dval(j)));
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle/zero inputs after reset give an all-zero row
    check({dig_d, dig_e, dig_f, dig_t, dig_w} == '0, "R1", "zero row after reset",
          64'({dig_d, dig_e, dig_f}), 64'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check_row(VECS[i]);
    end

    // R8: all-ones operands give digit values 2, 3...3, 1
    apply('{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF});
    check(dval(0) == 2, "R8", "digit 0 of all-ones", 64'(dval(0)), 64'd2);
    for (int j = 1; j < N; j++)
      check(dval(j) == 3, "R8", $sformatf("digit %0d of all-ones", j), 64'(dval(j)), 64'd3);
    check(dval(N) == 1, "R8", "top digit of all-ones", 64'(dval(N)), 64'd1);

    // R5: only the fourth operand set, no transfers anywhere
    apply('{16'h0000, 16'h0000, 16'h0000, 16'hFFFF});
    check(dig_e == '0 && dig_f == {1'b0, 16'hFFFF}, "R5", "x only, no transfer",
          64'({dig_e, dig_f}), 64'({17'h0, 17'h0FFFF}));

    // R1: return to zero after activity
    apply('{16'h0000, 16'h0000, 16'h0000, 16'h0000});
    check({dig_d, dig_e, dig_f, dig_t, dig_w} == '0, "R1", "zero row after activity",
          64'({dig_d, dig_e, dig_f}), 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule